// File: doc/BRIEF.md
# Display RAM Window Command Encoder

This block turns one pixel rectangle into the command stream that a panel controller needs before it takes pixel data. The rectangle is given as a top-left corner (X, Y), a width and a height, together with a grayscale-mode flag. A one-cycle start strobe latches the request. The block then sends thirteen bytes, each marked as either a command or a data byte. They set the X window, the Y window, the X address cursor and the Y address cursor, in that order.

The X axis is addressed in whole bytes of eight pixels, and both window bounds are inclusive. In grayscale mode the controller's X addressing is offset by eight pixels, so the block adds 8 to the X start, the X end and the X cursor. A rectangle whose X edges do not fall on byte boundaries sets an error flag, but its sequence is still sent. Every byte is offered with a valid/ready handshake. A done strobe follows the acceptance of the last byte. Pixel payload and the serial link are handled by other blocks.

Top module: `ram_window_encoder`

## Requirements
- R1: After reset, valid_o, done_o and misalign_o are all 0.
- R2: An accepted request produces exactly 13 bytes. Command bytes 0x44, 0x45, 0x4E and 0x4F sit at sequence positions 0, 3, 8 and 10. For those bytes is_cmd_o is 1. For every other byte it is 0.
- R3: In black/white mode (gray_i=0), byte 1 is (x>>3)&0xFF and byte 2 is ((x+width-1)>>3)&0xFF.
- R4: In grayscale mode (gray_i=1), byte 1 is ((x+8)>>3)&0xFF and byte 2 is ((x+width+7)>>3)&0xFF.
- R5: Bytes 4 to 7 are y low, y high, (y+height-1) low and (y+height-1) high. Low means bits 7:0 and high means bits 15:8.
- R6: Byte 9 equals byte 1, which is the X cursor including any grayscale offset. Bytes 11 and 12 are the low and high bytes of y.
- R7: misalign_o is set at request acceptance. It is 1 when the pixel X start (with offset) is not a multiple of 8, or when the pixel X end modulo 8 is not 7. It holds until the next accepted request, and the sequence is still sent in full.
- R8: While valid_o is 1 and ready_i is 0, the next cycle keeps valid_o at 1 and keeps byte_o and is_cmd_o unchanged.
- R9: done_o is high for exactly one cycle, the cycle after the last byte is accepted. valid_o is 0 in that cycle.
- R10: A start strobe is ignored while a sequence is in progress, including the cycle in which the last byte is accepted. A start in the done cycle is accepted.
- R11: width and height must be at least 1. Sums are computed without truncation before the byte extraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, accepted when idle |
| gray_i | input | 1 | 1 selects grayscale X offset |
| x_i | input | 8 | Top-left pixel X |
| y_i | input | 9 | Top-left pixel Y |
| width_i | input | 9 | Rectangle width in pixels (>=1) |
| height_i | input | 9 | Rectangle height in rows (>=1) |
| ready_i | input | 1 | Downstream accepts the offered byte |
| byte_o | output | 8 | Offered byte |
| is_cmd_o | output | 1 | 1 for a command byte, 0 for data |
| valid_o | output | 1 | A byte is offered |
| done_o | output | 1 | One-cycle pulse after the last byte |
| misalign_o | output | 1 | X edges of the last request not byte aligned |

## Verification
Two events can fall in the same cycle: the done pulse of one sequence and the acceptance of the next request. A start strobe in the cycle that accepts the last byte must be dropped, while one in the following cycle must be taken. The bench chains requests so that each new start is driven in the very cycle where done_o is seen. It also injects stray starts with different coordinates during random ready stalls, including the last-byte cycle. It then judges that every byte of each sequence matches the originally latched rectangle and that the done pulse shows valid_o low.

// File: rtl/rwe_pkg.sv
package rwe_pkg;
   localparam logic [7:0] CMD_XWIN = 8'h44;
   localparam logic [7:0] CMD_YWIN = 8'h45;
   localparam logic [7:0] CMD_XCUR = 8'h4E;
   localparam logic [7:0] CMD_YCUR = 8'h4F;
   localparam int         SEQ_LEN  = 13;
   localparam int         IDX_W    = $clog2(SEQ_LEN);

   // latched window image, in controller byte units
   typedef struct packed {
      logic [7:0]  xs;
      logic [7:0]  xe;
      logic [15:0] ys;
      logic [15:0] ye;
   } win_t;
endpackage

// File: rtl/rwe_geom.sv
module rwe_geom
   import rwe_pkg::*;
#(
   parameter int X_W      = 8,
   parameter int Y_W      = 9,
   parameter int W_W      = 9,
   parameter int H_W      = 9,
   parameter int GRAY_OFS = 8
) (
   input  logic [X_W-1:0] x_i,
   input  logic [Y_W-1:0] y_i,
   input  logic [W_W-1:0] width_i,
   input  logic [H_W-1:0] height_i,
   input  logic           gray_i,
   output win_t           win_o,
   output logic           misalign_o
);
   localparam int XS_W = ((X_W > W_W) ? X_W : W_W) + 2;
   localparam int YS_W = ((Y_W > H_W) ? Y_W : H_W) + 1;

   logic [XS_W-1:0] ofs, xs_pix, xe_pix;
   logic [YS_W-1:0] ye_pix;

   always_comb begin
      ofs    = gray_i ? XS_W'(GRAY_OFS) : '0;
      xs_pix = XS_W'(x_i) + ofs;
      xe_pix = xs_pix + XS_W'(width_i) - XS_W'(1);
      ye_pix = YS_W'(y_i) + YS_W'(height_i) - YS_W'(1);
      win_o.xs = 8'(xs_pix >> 3);
      win_o.xe = 8'(xe_pix >> 3);
      win_o.ys = 16'(y_i);
      win_o.ye = 16'(ye_pix);
      misalign_o = (xs_pix[2:0] != 3'd0) || (xe_pix[2:0] != 3'd7);
   end
endmodule

// File: rtl/rwe_seq.sv
module rwe_seq
   import rwe_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             ready_i,
   output logic             busy_o,
   output logic             load_o,
   output logic             done_o,
   output logic [IDX_W-1:0] idx_o
);
   logic fire, last;

   assign load_o = start_i && !busy_o;
   assign fire   = busy_o && ready_i;
   assign last   = (idx_o == IDX_W'(SEQ_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         done_o <= 1'b0;
         idx_o  <= '0;
      end else begin
         done_o <= fire && last;
         if (load_o) begin
            busy_o <= 1'b1;
            idx_o  <= '0;
         end else if (fire) begin
            if (last) busy_o <= 1'b0;
            else      idx_o  <= idx_o + IDX_W'(1);
         end
      end
   end
endmodule

// File: rtl/rwe_mux.sv
module rwe_mux
   import rwe_pkg::*;
(
   input  logic [IDX_W-1:0] idx_i,
   input  win_t             win_i,
   output logic [7:0]       byte_o,
   output logic             is_cmd_o
);
   always_comb begin
      is_cmd_o = 1'b0;
      case (idx_i)
         4'd0:  begin byte_o = CMD_XWIN; is_cmd_o = 1'b1; end
         4'd1:  byte_o = win_i.xs;
         4'd2:  byte_o = win_i.xe;
         4'd3:  begin byte_o = CMD_YWIN; is_cmd_o = 1'b1; end
         4'd4:  byte_o = win_i.ys[7:0];
         4'd5:  byte_o = win_i.ys[15:8];
         4'd6:  byte_o = win_i.ye[7:0];
         4'd7:  byte_o = win_i.ye[15:8];
         4'd8:  begin byte_o = CMD_XCUR; is_cmd_o = 1'b1; end
         4'd9:  byte_o = win_i.xs;
         4'd10: begin byte_o = CMD_YCUR; is_cmd_o = 1'b1; end
         4'd11: byte_o = win_i.ys[7:0];
         4'd12: byte_o = win_i.ys[15:8];
         default: byte_o = 8'h00;
      endcase
   end
endmodule

// File: rtl/ram_window_encoder.sv
module ram_window_encoder
   import rwe_pkg::*;
#(
   parameter int X_W      = 8,
   parameter int Y_W      = 9,
   parameter int W_W      = 9,
   parameter int H_W      = 9,
   parameter int GRAY_OFS = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic           gray_i,
   input  logic [X_W-1:0] x_i,
   input  logic [Y_W-1:0] y_i,
   input  logic [W_W-1:0] width_i,
   input  logic [H_W-1:0] height_i,
   input  logic           ready_i,
   output logic [7:0]     byte_o,
   output logic           is_cmd_o,
   output logic           valid_o,
   output logic           done_o,
   output logic           misalign_o
);
   generate
      if (X_W < 3 || X_W > 11) begin : g_bad_xw
         $error("X_W out of range");
      end
      if (((Y_W > H_W) ? Y_W : H_W) + 1 > 16) begin : g_bad_yw
         $error("Y sum exceeds two bytes");
      end
      if (GRAY_OFS % 8 != 0) begin : g_bad_ofs
         $error("GRAY_OFS must be a byte multiple");
      end
   endgenerate

   win_t             win_d, win_q;
   logic             mis_d, mis_q;
   logic             busy, load;
   logic [IDX_W-1:0] idx;

   rwe_geom #(
      .X_W(X_W), .Y_W(Y_W), .W_W(W_W), .H_W(H_W), .GRAY_OFS(GRAY_OFS)
   ) u_geom (
      .x_i(x_i), .y_i(y_i), .width_i(width_i), .height_i(height_i),
      .gray_i(gray_i), .win_o(win_d), .misalign_o(mis_d)
   );

   rwe_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(ready_i),
      .busy_o(busy), .load_o(load), .done_o(done_o), .idx_o(idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
         mis_q <= 1'b0;
      end else if (load) begin
         win_q <= win_d;
         mis_q <= mis_d;
      end
   end

   rwe_mux u_mux (
      .idx_i(idx), .win_i(win_q), .byte_o(byte_o), .is_cmd_o(is_cmd_o)
   );

   assign valid_o    = busy;
   assign misalign_o = mis_q;
endmodule

// File: rtl/rwe_checks.sv
module rwe_checks (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       ready_i,
   input logic [7:0] byte_o,
   input logic       is_cmd_o,
   input logic       valid_o,
   input logic       done_o,
   input logic       misalign_o
);
   a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !ready_i |=> valid_o && $stable(byte_o) && $stable(is_cmd_o));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !valid_o);

   a_r2_opens_with_xwin: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> is_cmd_o && byte_o == 8'h44);

   a_r7_flag_steady: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && $past(valid_o) |-> $stable(misalign_o));

   a_r10_stray_start: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && start_i && !ready_i |=> $stable(byte_o));
endmodule

bind ram_window_encoder rwe_checks u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(ready_i),
   .byte_o(byte_o), .is_cmd_o(is_cmd_o), .valid_o(valid_o),
   .done_o(done_o), .misalign_o(misalign_o)
);

// File: tb/ram_window_encoder_test.sv
module ram_window_encoder_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, gray_i = 1'b0, ready_i = 1'b0;
   logic [7:0] x_i = '0;
   logic [8:0] y_i = '0, width_i = '0, height_i = '0;
   logic [7:0] byte_o;
   logic       is_cmd_o, valid_o, done_o, misalign_o;

   int n_vec = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   ram_window_encoder uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .gray_i(gray_i),
      .x_i(x_i), .y_i(y_i), .width_i(width_i), .height_i(height_i),
      .ready_i(ready_i), .byte_o(byte_o), .is_cmd_o(is_cmd_o),
      .valid_o(valid_o), .done_o(done_o), .misalign_o(misalign_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // {is_cmd, byte} expected at sequence position idx
   function automatic int exp_byte(int idx, int x, int y, int w, int h, bit g);
      int xs, xe, ye;
      xs = x + (g ? 8 : 0);
      xe = xs + w - 1;
      ye = y + h - 1;
      case (idx)
         0:  return 256 | 8'h44;
         1:  return (xs >> 3) & 255;
         2:  return (xe >> 3) & 255;
         3:  return 256 | 8'h45;
         4:  return y & 255;
         5:  return (y >> 8) & 255;
         6:  return ye & 255;
         7:  return (ye >> 8) & 255;
         8:  return 256 | 8'h4E;
         9:  return (xs >> 3) & 255;
         10: return 256 | 8'h4F;
         11: return y & 255;
         default: return (y >> 8) & 255;
      endcase
   endfunction

   function automatic bit exp_mis(int x, int w, bit g);
      int xs;
      xs = x + (g ? 8 : 0);
      return ((xs % 8) != 0) || (((xs + w - 1) % 8) != 7);
   endfunction

   function automatic string tag_of(int idx, bit g);
      if (idx == 0 || idx == 3 || idx == 8 || idx == 10) return "R2";
      if (idx == 1 || idx == 2) return g ? "R4" : "R3";
      if (idx >= 4 && idx <= 7) return "R5";
      return "R6";
   endfunction

   // entered at a negedge; leaves at the negedge showing done
   task automatic run(int x, int y, int w, int h, bit g, int stall_pct, bit junk);
      int  k = 0;
      int  guard = 0;
      bit  prev_stall = 0;
      int  prev = 0;
      int  cur;
      bit  rdy;
      start_i = 1'b1; gray_i = g; x_i = 8'(x); y_i = 9'(y);
      width_i = 9'(w); height_i = 9'(h);
      while (k < 13) begin
         @(negedge clk);
         start_i = 1'b0;
         guard++;
         if (guard > 400) begin
            chk(0, "R9 sequence never completed", k, 13);
            return;
         end
         cur = {23'd0, is_cmd_o, byte_o};
         if (guard == 1) chk(done_o == 1'b0, "R9 done not single", done_o, 0);
         chk(valid_o == 1'b1, "R8 valid held during sequence", valid_o, 1);
         if (prev_stall) chk(cur == prev, "R8 byte held while stalled", cur, prev);
         rdy = ($urandom_range(0, 99) >= stall_pct);
         if (rdy) begin
            chk(cur == exp_byte(k, x, y, w, h, g), tag_of(k, g), cur, exp_byte(k, x, y, w, h, g));
            k++;
         end
         prev_stall = !rdy;
         prev = cur;
         ready_i = rdy;
         if (junk && $urandom_range(0, 2) == 0) begin
            // R10: stray request while busy must not disturb the sequence
            start_i = 1'b1; gray_i = ~g;
            x_i = 8'($urandom_range(0, 255)); y_i = 9'($urandom_range(0, 511));
            width_i = 9'($urandom_range(1, 256)); height_i = 9'($urandom_range(1, 511));
         end
      end
      @(negedge clk);
      start_i = 1'b0; ready_i = 1'b0;
      chk(done_o == 1'b1, "R9 done after last byte", done_o, 1);
      chk(valid_o == 1'b0, "R9 valid low with done", valid_o, 0);
      chk(misalign_o == exp_mis(x, w, g), "R7 misalign flag", misalign_o, exp_mis(x, w, g));
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(valid_o == 1'b0, "R1 valid at reset", valid_o, 0);
      chk(done_o == 1'b0, "R1 done at reset", done_o, 0);
      chk(misalign_o == 1'b0, "R1 misalign at reset", misalign_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corners (R3..R7, R11)
      run(0,   0,   128, 296, 0, 0,  0);
      run(0,   0,   128, 296, 1, 30, 0);
      run(3,   5,   10,  1,   0, 0,  0);
      run(8,   0,   8,   1,   1, 50, 1);
      run(120, 295, 8,   1,   0, 0,  1);
      run(255, 511, 256, 511, 1, 20, 1);
      run(16,  256, 1,   1,   0, 70, 1);
      // idle gap, then a start alone
      repeat (2) @(negedge clk);
      chk(valid_o == 1'b0, "R10 idle stays idle", valid_o, 0);
      for (int i = 0; i < 60; i++) begin
         run($urandom_range(0, 255), $urandom_range(0, 511),
             $urandom_range(1, 256), $urandom_range(1, 511),
             1'($urandom_range(0, 1)), $urandom_range(0, 60),
             1'($urandom_range(0, 1)));
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule